// File: doc/BRIEF.md
# General-Purpose Pin Controller with Event Detection

This block controls 54 general-purpose pins from a plain 32-bit register port. Each pin carries a 3-bit function code that is exported to the pad ring. The output enable is raised only for the plain-output code. The output latches are changed through separate set and clear words, so software never needs a read-modify-write. The sampled pin levels can be read back after a two-flop synchroniser. The pins are grouped into two 32-bit banks, and bank 1 populates only its low 22 bits.

Every pin has four event sources. Rising edge and falling edge are found by comparing two successive synchronised samples. High level and low level are present while the synchronised pin holds that value. Each source has its own enable, and any mix of them can be on at once. A detected event sets a sticky status bit that software clears by writing a one to it. The single interrupt output is a registered OR of every status bit in both banks. Two further enable words exist for asynchronous edge detection, which this block does not implement. Those words only hold and return what was written to them.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: A synchronous reset clears every function code, output latch, enable word and status bit. After it, irq, pin_out and rdata read zero.
- R2: Pin n has its function code in register word n/10 (byte offset 4*(n/10), first word at 0x00), at bits 3*(n mod 10)+2 down to 3*(n mod 10). Bits 30 and 31 of every such word, and bits 12 and up of word 5, read zero.
- R3: pin_oe for a pin is 1 only while its code is 001. The code goes out unchanged on func_sel, at bits 3n+2 to 3n. Code 000 is input, 100 to 111 are alternates 0 to 3, 011 is alternate 4 and 010 is alternate 5.
- R4: Writing to 0x1C or 0x20 sets the output latch of each pin whose data bit is 1. Writing to 0x28 or 0x2C clears it. Data bits that are 0 change nothing. All four of these words read zero.
- R5: The level words at 0x34 (pins 0 to 31) and 0x38 (pins 32 to 53) return the pin inputs after two synchroniser stages.
- R6: With the rising enable (0x4C/0x50) or the falling enable (0x58/0x5C) set, a matching change between two successive synchronised samples sets the pin's status bit. The bit stays set after the pin returns. An edge of the other direction does not set it.
- R7: With the high enable (0x64/0x68) or the low enable (0x70/0x74) set, the status bit is set on every cycle in which the synchronised level matches. A clear does not stick while that level lasts.
- R8: The status words at 0x40/0x44 are cleared by writing 1 to a bit. Zero bits leave status unchanged, and status never drops without such a write.
- R9: irq is 1 in the cycle after any status bit is 1, and 0 in the cycle after all status bits are 0.
- R10: The words at 0x7C/0x80 and 0x88/0x8C store and read back what was written, and never set any status bit.
- R11: For every bank-1 word, bits 22 to 31 read zero and writing them has no effect.
- R12: rdata is loaded with the addressed word on the clock edge where rd_en is high, and holds its value while rd_en is low.
- R13: An access whose address has either of its two low bits set reads zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| pin_in | input | 54 | Raw pin inputs, asynchronous |
| pin_out | output | 54 | Output latch values |
| pin_oe | output | 54 | Output enable, high for function code 001 |
| func_sel | output | 162 | Per-pin 3-bit function codes |
| irq | output | 1 | Combined event interrupt |

## Verification
Some properties are checked on every cycle. Status bits never fall without a clear write. A pin with all detect sources disabled never raises status. Set and clear writes reach the latches of bank 0. irq follows pending status, and rdata holds between reads. Other behaviour only shows up in directed and random scenarios run against a cycle-accurate model. This covers the layout of the function fields, the timing through the synchroniser, the difference between edge and level sources, a clear being undone by a level that is still present, the async-enable words causing no events, and the masking of bank-1 bits and misaligned addresses.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  // Word indices (byte address / 4); ordering is fixed by software drivers.
  localparam int IDX_FSEL = 0;
  localparam int IDX_SET  = 7;
  localparam int IDX_CLR  = 10;
  localparam int IDX_LEV  = 13;
  localparam int IDX_EDS  = 16;
  localparam int IDX_REN  = 19;
  localparam int IDX_FEN  = 22;
  localparam int IDX_HEN  = 25;
  localparam int IDX_LEN  = 28;
  localparam int IDX_AREN = 31;
  localparam int IDX_AFEN = 34;
  localparam int NWORDS   = 36;

  localparam int BANK_W = 32;

  typedef enum logic [2:0] {
    FN_INPUT  = 3'd0,
    FN_OUTPUT = 3'd1,
    FN_ALT5   = 3'd2,
    FN_ALT4   = 3'd3,
    FN_ALT0   = 3'd4,
    FN_ALT1   = 3'd5,
    FN_ALT2   = 3'd6,
    FN_ALT3   = 3'd7
  } pin_fn_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 54,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int W = 54
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lev,
  input  logic [W-1:0] ren,
  input  logic [W-1:0] fen,
  input  logic [W-1:0] hen,
  input  logic [W-1:0] len,
  input  logic [W-1:0] clr,
  output logic [W-1:0] eds,
  output logic         irq
);

  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  // Per-pin event sources; level sources re-fire every cycle they hold.
  for (genvar p = 0; p < W; p++) begin : g_hit
    assign hit[p] = (ren[p] &  lev[p] & ~prev_q[p])
                  | (fen[p] & ~lev[p] &  prev_q[p])
                  | (hen[p] &  lev[p])
                  | (len[p] & ~lev[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      eds    <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= lev;
      eds    <= (eds & ~clr) | hit;   // a new event wins over a clear
      irq    <= |eds;
    end
  end

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS    = 54,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [3*NUM_PINS-1:0] func_sel,
  output logic                  irq
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]        widx;
  logic                     aligned;
  logic [NWORDS-1:0]        wr_word;
  logic [NUM_PINS-1:0]      ren_q, fen_q, hen_q, len_q, aren_q, afen_q;
  logic [NUM_PINS-1:0][2:0] fsel_q;
  logic [NUM_PINS-1:0]      lev_s, eds_q, eds_clr;
  logic [31:0]              rd_val;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    for (int i = 0; i < NWORDS; i++) begin
      wr_word[i] = wr_en && aligned && (int'(widx) == i);
    end
  end

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lev_s)
  );

  // Register file: one loop over pins, field position derived per pin.
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      ren_q   <= '0;
      fen_q   <= '0;
      hen_q   <= '0;
      len_q   <= '0;
      aren_q  <= '0;
      afen_q  <= '0;
      fsel_q  <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_word[IDX_SET + p/BANK_W] && wdata[p%BANK_W]) pin_out[p] <= 1'b1;
        if (wr_word[IDX_CLR + p/BANK_W] && wdata[p%BANK_W]) pin_out[p] <= 1'b0;
        if (wr_word[IDX_REN  + p/BANK_W]) ren_q[p]  <= wdata[p%BANK_W];
        if (wr_word[IDX_FEN  + p/BANK_W]) fen_q[p]  <= wdata[p%BANK_W];
        if (wr_word[IDX_HEN  + p/BANK_W]) hen_q[p]  <= wdata[p%BANK_W];
        if (wr_word[IDX_LEN  + p/BANK_W]) len_q[p]  <= wdata[p%BANK_W];
        if (wr_word[IDX_AREN + p/BANK_W]) aren_q[p] <= wdata[p%BANK_W];
        if (wr_word[IDX_AFEN + p/BANK_W]) afen_q[p] <= wdata[p%BANK_W];
        if (wr_word[IDX_FSEL + p/10]) fsel_q[p] <= wdata[3*(p%10) +: 3];
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_oe[p]          = (fsel_q[p] == FN_OUTPUT);
    assign func_sel[3*p +: 3] = fsel_q[p];
    assign eds_clr[p]         = wr_word[IDX_EDS + p/BANK_W] & wdata[p%BANK_W];
  end

  gpio_evt_detect #(.W(NUM_PINS)) u_det (
    .clk (clk),
    .rst (rst),
    .lev (lev_s),
    .ren (ren_q),
    .fen (fen_q),
    .hen (hen_q),
    .len (len_q),
    .clr (eds_clr),
    .eds (eds_q),
    .irq (irq)
  );

  // Read mux: every pin drops its bit into the word that owns it.
  always_comb begin
    rd_val = '0;
    if (aligned) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (int'(widx) == IDX_FSEL + p/10)      rd_val[3*(p%10) +: 3] = fsel_q[p];
        if (int'(widx) == IDX_LEV  + p/BANK_W)  rd_val[p%BANK_W] = lev_s[p];
        if (int'(widx) == IDX_EDS  + p/BANK_W)  rd_val[p%BANK_W] = eds_q[p];
        if (int'(widx) == IDX_REN  + p/BANK_W)  rd_val[p%BANK_W] = ren_q[p];
        if (int'(widx) == IDX_FEN  + p/BANK_W)  rd_val[p%BANK_W] = fen_q[p];
        if (int'(widx) == IDX_HEN  + p/BANK_W)  rd_val[p%BANK_W] = hen_q[p];
        if (int'(widx) == IDX_LEN  + p/BANK_W)  rd_val[p%BANK_W] = len_q[p];
        if (int'(widx) == IDX_AREN + p/BANK_W)  rd_val[p%BANK_W] = aren_q[p];
        if (int'(widx) == IDX_AFEN + p/BANK_W)  rd_val[p%BANK_W] = afen_q[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         wdata,
  input logic [31:0]         rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                irq,
  input logic [NUM_PINS-1:0] eds,
  input logic [NUM_PINS-1:0] ren,
  input logic [NUM_PINS-1:0] fen,
  input logic [NUM_PINS-1:0] hen,
  input logic [NUM_PINS-1:0] len
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && pin_out == '0 && rdata == '0));

  // R4
  a_r4_set_reaches_latch: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(addr) == 28) |=> ((pin_out[31:0] & $past(wdata)) == $past(wdata)));

  // R4
  a_r4_clear_reaches_latch: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(addr) == 40) |=> ((pin_out[31:0] & $past(wdata)) == 32'd0));

  // R6, R7: no enabled source means no new status
  a_r6_masked_pins_quiet: assert property (@(posedge clk) disable iff (rst)
    ((ren | fen | hen | len) == '0 && eds == '0) |=> (eds == '0));

  // R8
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (int'(addr) == 64 || int'(addr) == 68)) |=> ((eds & $past(eds)) == $past(eds)));

  // R9
  a_r9_irq_raised: assert property (@(posedge clk) disable iff (rst)
    (|eds) |=> irq);

  // R12
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_evt_ctrl gpio_evt_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pin_out (pin_out),
  .irq     (irq),
  .eds     (eds_q),
  .ren     (ren_q),
  .fen     (fen_q),
  .hen     (hen_q),
  .len     (len_q)
);

// File: tb/test_gpio_evt_ctrl.sv
module test_gpio_evt_ctrl;

  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [3*NP-1:0] func_sel;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_evt_ctrl i_gpio_evt_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pins), .pin_out(pin_out),
    .pin_oe(pin_oe), .func_sel(func_sel), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [NP-1:0] m_lat, m_ren, m_fen, m_hen, m_len, m_aren, m_afen;
  bit [NP-1:0] m_eds, m_s1, m_lev, m_prev;
  bit [2:0]    m_fs [NP];
  bit          m_irq;
  bit [31:0]   m_rd;

  function automatic bit [31:0] bank_word(bit [NP-1:0] v, int b);
    bit [31:0] r = '0;
    for (int k = 0; k < 32; k++) if (32*b + k < NP) r[k] = v[32*b + k];
    return r;
  endfunction

  function automatic bit [31:0] m_read(int a);
    int w;
    bit [31:0] r = '0;
    if (a % 4 != 0) return 0;
    w = a / 4;
    if (w < 6) begin
      for (int p = 0; p < NP; p++) if (p / 10 == w) r[3*(p%10) +: 3] = m_fs[p];
      return r;
    end
    case (w)
      13, 14: return bank_word(m_lev,  w - 13);
      16, 17: return bank_word(m_eds,  w - 16);
      19, 20: return bank_word(m_ren,  w - 19);
      22, 23: return bank_word(m_fen,  w - 22);
      25, 26: return bank_word(m_hen,  w - 25);
      28, 29: return bank_word(m_len,  w - 28);
      31, 32: return bank_word(m_aren, w - 31);
      34, 35: return bank_word(m_afen, w - 34);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lat = '0; m_ren = '0; m_fen = '0; m_hen = '0; m_len = '0;
      m_aren = '0; m_afen = '0; m_eds = '0; m_s1 = '0; m_lev = '0;
      m_prev = '0; m_irq = 0; m_rd = '0;
      for (int p = 0; p < NP; p++) m_fs[p] = '0;
    end else begin
      bit [NP-1:0] hit, clr;
      int a, w, b;
      a = int'(addr);
      w = a / 4;
      if (rd_en) m_rd = m_read(a);
      m_irq = |m_eds;
      hit = '0; clr = '0;
      for (int p = 0; p < NP; p++) begin
        if (m_ren[p] && m_lev[p] && !m_prev[p]) hit[p] = 1;
        if (m_fen[p] && !m_lev[p] && m_prev[p]) hit[p] = 1;
        if (m_hen[p] && m_lev[p])  hit[p] = 1;
        if (m_len[p] && !m_lev[p]) hit[p] = 1;
      end
      if (wr_en && a % 4 == 0 && (w == 16 || w == 17)) begin
        b = w - 16;
        for (int k = 0; k < 32; k++) if (32*b + k < NP && wdata[k]) clr[32*b + k] = 1;
      end
      m_eds = (m_eds & ~clr) | hit;
      m_prev = m_lev; m_lev = m_s1; m_s1 = pins;
      if (wr_en && a % 4 == 0) begin
        if (w < 6) begin
          for (int p = 0; p < NP; p++) if (p / 10 == w) m_fs[p] = wdata[3*(p%10) +: 3];
        end
        for (int k = 0; k < 32; k++) begin
          for (int bb = 0; bb < 2; bb++) begin
            int p;
            p = 32*bb + k;
            if (p < NP) begin
              if (w == 7  + bb && wdata[k]) m_lat[p] = 1;
              if (w == 10 + bb && wdata[k]) m_lat[p] = 0;
              if (w == 19 + bb) m_ren[p]  = wdata[k];
              if (w == 22 + bb) m_fen[p]  = wdata[k];
              if (w == 25 + bb) m_hen[p]  = wdata[k];
              if (w == 28 + bb) m_len[p]  = wdata[k];
              if (w == 31 + bb) m_aren[p] = wdata[k];
              if (w == 34 + bb) m_afen[p] = wdata[k];
            end
          end
        end
      end
    end
  end

  // Compare with the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (model_on && !rst) begin
      bit bad;
      bad = 0;
      checks++;
      if (irq !== m_irq) begin
        bad = 1; $display("FAIL R9 irq actual %0b expected %0b", irq, m_irq);
      end
      if (pin_out !== m_lat) begin
        bad = 1; $display("FAIL R4 pin_out actual %h expected %h", pin_out, m_lat);
      end
      if (rdata !== m_rd) begin
        bad = 1; $display("FAIL R12 rdata actual %h expected %h", rdata, m_rd);
      end
      for (int p = 0; p < NP; p++) begin
        if (func_sel[3*p +: 3] !== m_fs[p] || pin_oe[p] !== (m_fs[p] == 3'd1)) begin
          bad = 1;
          $display("FAIL R3 pin %0d code actual %0d/%0b expected %0d/%0b",
                   p, func_sel[3*p +: 3], pin_oe[p], m_fs[p], m_fs[p] == 3'd1);
        end
      end
      if (bad) errors++;
    end
  end

  // ---------------- stimulus helpers (start just after a negedge) -------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    model_on = 1;
    rst = 0;
    settle(1);

    // R1 reset state
    chk(irq == 0 && pin_out == '0, "R1 irq/pin_out", {irq, pin_out}, 0);
    rd_chk(8'h00, 0, "R1 fsel0");
    rd_chk(8'h40, 0, "R1 status0");
    rd_chk(8'h4C, 0, "R1 rise en");

    // R2 field layout, R3 output enable and code export
    wr(8'h04, 32'hC000_0801);
    rd_chk(8'h04, 32'h0000_0801, "R2 fsel word1");
    chk(pin_oe[10] == 1 && pin_oe[13] == 0, "R3 oe", {pin_oe[13], pin_oe[10]}, 64'h1);
    chk(func_sel[41:39] == 3'd4, "R3 code pin13", func_sel[41:39], 4);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk(8'h14, 32'h0000_0FFF, "R2 fsel word5");
    chk(pin_oe[53:50] == 0, "R3 oe alt3", pin_oe[53:50], 0);

    // R4 set / clear, R11 bank-1 width
    wr(8'h1C, 32'h0000_00F0);
    wr(8'h20, 32'hFFFF_FFFF);
    chk(pin_out == {22'h3FFFFF, 32'h0000_00F0}, "R4 set", pin_out, {22'h3FFFFF, 32'hF0});
    wr(8'h28, 32'h0000_0030);
    chk(pin_out[31:0] == 32'hC0, "R4 clear", pin_out[31:0], 32'hC0);
    rd_chk(8'h1C, 0, "R4 set reads 0");
    rd_chk(8'h2C, 0, "R4 clr reads 0");
    wr(8'h2C, 32'hFFFF_FFFF);
    chk(pin_out[53:32] == 0, "R4 clear bank1", pin_out[53:32], 0);

    // R13 misaligned write ignored
    wr(8'h1D, 32'hFFFF_FFFF);
    chk(pin_out[31:0] == 32'hC0, "R13 misaligned", pin_out[31:0], 32'hC0);
    rd_chk(8'h05, 0, "R13 misaligned read");

    // R5 level through synchroniser
    pins = {22'h2AAAAA, 32'h1234_5678};
    settle(3);
    rd_chk(8'h34, 32'h1234_5678, "R5 level bank0");
    rd_chk(8'h38, 32'h002A_AAAA, "R5 R11 level bank1");
    pins = '0;
    settle(4);

    // R6 rising edge, sticky; R8 clear; R9 irq
    wr(8'h4C, 32'h1);
    pins[0] = 1;
    settle(4);
    rd_chk(8'h40, 32'h1, "R6 rising");
    chk(irq == 1, "R9 irq high", irq, 1);
    pins[0] = 0;
    settle(4);
    rd_chk(8'h40, 32'h1, "R6 sticky");
    wr(8'h40, 32'hFFFF_FFFE);
    rd_chk(8'h40, 32'h1, "R8 zero bits");
    wr(8'h40, 32'h1);
    rd_chk(8'h40, 32'h0, "R8 w1c");
    settle(1);
    chk(irq == 0, "R9 irq low", irq, 0);
    wr(8'h4C, 32'h0);

    // R6 falling only on pin 33
    wr(8'h5C, 32'h2);
    pins[33] = 1;
    settle(4);
    rd_chk(8'h44, 32'h0, "R6 rise ignored by fall");
    pins[33] = 0;
    settle(4);
    rd_chk(8'h44, 32'h2, "R6 falling");
    wr(8'h44, 32'h2);
    rd_chk(8'h44, 32'h0, "R8 bank1 clear");
    wr(8'h5C, 32'h0);

    // R7 high level re-asserts while present
    wr(8'h64, 32'h4);
    pins[2] = 1;
    settle(4);
    wr(8'h40, 32'h4);
    rd_chk(8'h40, 32'h4, "R7 high reasserts");
    pins[2] = 0;
    settle(4);
    wr(8'h40, 32'h4);
    rd_chk(8'h40, 32'h0, "R7 high cleared");
    wr(8'h64, 32'h0);

    // R7 low level on pin 40
    wr(8'h74, 32'h100);
    settle(2);
    rd_chk(8'h44, 32'h100, "R7 low level");
    pins[40] = 1;
    settle(4);
    wr(8'h44, 32'h100);
    rd_chk(8'h44, 32'h0, "R7 low cleared");
    wr(8'h74, 32'h0);

    // R10 async enables are storage only
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
    pins = '1;
    settle(4);
    pins = '0;
    settle(4);
    rd_chk(8'h40, 0, "R10 no events bank0");
    rd_chk(8'h44, 0, "R10 no events bank1");
    chk(irq == 0, "R10 irq", irq, 0);
    rd_chk(8'h7C, 32'hFFFF_FFFF, "R10 readback");
    rd_chk(8'h8C, 32'h003F_FFFF, "R10 R11 readback");
    settle(3);
    chk(rdata == 32'h003F_FFFF, "R12 rdata holds", rdata, 32'h003F_FFFF);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      if (r < 5) pins = pins ^ {$urandom, $urandom};
      wr_en = (r >= 10);
      rd_en = (r[0] == 1'b1);
      addr  = 8'(($urandom % 36) * 4 + (($urandom % 16 == 0) ? 1 : 0));
      wdata = $urandom;
      @(negedge clk);
      wr_en = 0; rd_en = 0;
    end
    settle(2);

    done = 1;
    summary();
    $finish;
  end

endmodule